// File: doc/BRIEF.md
# Two-Channel Successive-Approximation Conversion Sequencer

This block sequences an 8-bit successive-approximation conversion for an analog input port that has two channels. A host selects the block with an active-low chip select and pulses an active-low write strobe. When the strobe returns high, the block latches the channel select and asserts its busy/hold request, which tells the external track-and-hold to freeze the input. From then on it walks a trial code from the most significant bit down to the least. It drives each trial code, together with the held channel, to an external DAC and comparator, and it samples the single comparator bit that comes back.

Decisions follow the falling edges of a separate conversion clock. The host system supplies this clock; it is synchronous to the system clock and slower than it. After the last decision the finished code and its channel are copied into an output latch in the same cycle. The active-low end-of-conversion flag goes low, and the approximation register clears itself for the next conversion. A new accepted start clears the flag, and so does a read (chip select and read strobe both low).

Top module: `sar_conv_seq`

## Requirements
- R1: After reset, busy is 0, eoc_n is 1, trial_code is 0 and result is 0.
- R2: When cs_n is low in the cycle where wr_n is first seen high after being low, the conversion starts. busy is 1 at the next clock edge, trial_code is 0x80 (only bit 7 set) and trial_ch holds ch_sel (0 = channel A, 1 = channel B).
- R3: The first falling edge of conv_clk that the block sees while busy decides bit 7. Each later falling edge decides the next lower bit. A conversion ends after exactly 8 falling edges, and trial_code does not change between decision edges.
- R4: Each trial sets the bit under test to 1. The bit stays 1 if cmp_in is 1 (input at or above the trial level) and is cleared otherwise. With an ideal comparator, result equals the held input code.
- R5: On the clock edge of the bit-0 decision, result and result_ch are loaded, eoc_n goes to 0 and busy goes to 0, all together.
- R6: Whenever busy is 0, trial_code is 0; the register clears at completion.
- R7: A write strobe that arrives while busy is ignored. The channel does not change, the decision count does not change, and the result is that of the original start.
- R8: eoc_n returns to 1 at the clock edge after an accepted start, or at a clock edge where cs_n and rd_n are both low. result keeps its value.
- R9: A write strobe with cs_n high starts nothing. busy stays 0 and eoc_n keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cs_n | input | 1 | Active-low chip select |
| wr_n | input | 1 | Active-low write strobe; its rising edge starts a conversion |
| rd_n | input | 1 | Active-low read strobe; clears the completion flag |
| ch_sel | input | 1 | Channel select, 0 = A, 1 = B, captured at start |
| conv_clk | input | 1 | Conversion clock, synchronous to clk; falling edges decide bits |
| cmp_in | input | 1 | Comparator result, 1 when input is at or above trial level |
| trial_code | output | 8 | Trial code for the external DAC |
| trial_ch | output | 1 | Channel held for the current conversion |
| busy | output | 1 | Hold request / conversion in progress |
| result | output | 8 | Output latch with the last finished code |
| result_ch | output | 1 | Channel of the code in the output latch |
| eoc_n | output | 1 | Active-low end-of-conversion flag |

## Verification
The bench runs codes at both ends of the range (0x00, 0xFF) and alternating bit patterns on both channels. A design that inverted the keep/clear rule, or decided bits in the wrong order, would return a wrong code for at least one of them. For every conversion the bench counts the falling edges of the conversion clock between start and flag. An extra or missing decision edge, or a decision made on the start cycle, shows up as a count other than 8. Directed cases send a write strobe during a conversion with the other channel selected, send a strobe while deselected, and read to drop the flag. A block that restarted, switched channel, started without select, or held the flag after a read would fail one of these.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;
  localparam int unsigned DEF_CODE_W = 8;
  typedef enum logic { CH_A = 1'b0, CH_B = 1'b1 } chan_e;
endpackage

// File: rtl/sar_rst_sync.sv
module sar_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] pipe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe_q <= 2'b00;
    else        pipe_q <= {pipe_q[0], 1'b1};
  end

  assign rst_sync_n = pipe_q[1];
endmodule

// File: rtl/sar_edge_tap.sv
module sar_edge_tap #(
  parameter bit RISE    = 1'b1,
  parameter bit IDLE_LV = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic level,
  output logic pulse
);
  logic last_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) last_q <= IDLE_LV;
    else        last_q <= level;
  end

  generate
    if (RISE) begin : g_rise
      assign pulse = level & ~last_q;
    end else begin : g_fall
      assign pulse = ~level & last_q;
    end
  endgenerate
endmodule

// File: rtl/sar_core.sv
module sar_core
  import sar_seq_pkg::*;
#(
  parameter int unsigned CODE_W = DEF_CODE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  chan_e             ch_in,
  input  logic              step,
  input  logic              cmp_in,
  output logic              busy,
  output chan_e             ch_held,
  output logic [CODE_W-1:0] trial,
  output logic              done,
  output logic [CODE_W-1:0] fin_code
);
  localparam int unsigned PTR_W = $clog2(CODE_W);
  localparam logic [CODE_W-1:0] MSB_ONLY = {1'b1, {(CODE_W-1){1'b0}}};

  logic              busy_q, busy_d;
  logic [CODE_W-1:0] sar_q, sar_d;
  logic [PTR_W-1:0]  ptr_q, ptr_d;
  chan_e             ch_q;
  logic              upd_en;

  always_comb begin
    busy_d   = busy_q;
    sar_d    = sar_q;
    ptr_d    = ptr_q;
    done     = 1'b0;
    fin_code = sar_q;
    fin_code[ptr_q] = cmp_in;
    if (start) begin
      busy_d = 1'b1;
      sar_d  = MSB_ONLY;
      ptr_d  = PTR_W'(CODE_W - 1);
    end else if (busy_q && step) begin
      sar_d[ptr_q] = cmp_in;
      if (ptr_q == '0) begin
        done   = 1'b1;
        busy_d = 1'b0;
        sar_d  = '0;
      end else begin
        sar_d[ptr_q - PTR_W'(1)] = 1'b1;
        ptr_d = ptr_q - PTR_W'(1);
      end
    end
  end

  assign upd_en = start | (busy_q & step);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      sar_q  <= '0;
      ptr_q  <= '0;
      ch_q   <= CH_A;
    end else if (upd_en) begin
      busy_q <= busy_d;
      sar_q  <= sar_d;
      ptr_q  <= ptr_d;
      if (start) ch_q <= ch_in;
    end
  end

  assign busy    = busy_q;
  assign trial   = sar_q;
  assign ch_held = ch_q;

  assert_start_msb_R2: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (sar_q == MSB_ONLY && busy_q));
  assert_idle_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_q |-> (sar_q == '0));
  assert_hold_between_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !step) |=> $stable(sar_q));
  assert_chan_kept_R7: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |=> $stable(ch_q));
endmodule

// File: rtl/sar_result_latch.sv
module sar_result_latch
  import sar_seq_pkg::*;
#(
  parameter int unsigned CODE_W = DEF_CODE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [CODE_W-1:0] code,
  input  chan_e             ch,
  input  logic              start,
  input  logic              rd,
  output logic [CODE_W-1:0] result,
  output chan_e             result_ch,
  output logic              eoc_n
);
  logic [CODE_W-1:0] res_q, res_d;
  chan_e             rch_q, rch_d;
  logic              eoc_q, eoc_d;

  always_comb begin
    res_d = res_q;
    rch_d = rch_q;
    eoc_d = eoc_q;
    if (load) begin
      res_d = code;
      rch_d = ch;
      eoc_d = 1'b0;
    end else if (start || rd) begin
      eoc_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q <= '0;
      rch_q <= CH_A;
      eoc_q <= 1'b1;
    end else begin
      if (load) begin
        res_q <= res_d;
        rch_q <= rch_d;
      end
      eoc_q <= eoc_d;
    end
  end

  assign result    = res_q;
  assign result_ch = rch_q;
  assign eoc_n     = eoc_q;

  assert_result_kept_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(res_q));
  assert_flag_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && (start || rd)) |=> eoc_q);
endmodule

// File: rtl/sar_conv_seq.sv
module sar_conv_seq
  import sar_seq_pkg::*;
#(
  parameter int unsigned CODE_W = DEF_CODE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              wr_n,
  input  logic              rd_n,
  input  logic              ch_sel,
  input  logic              conv_clk,
  input  logic              cmp_in,
  output logic [CODE_W-1:0] trial_code,
  output logic              trial_ch,
  output logic              busy,
  output logic [CODE_W-1:0] result,
  output logic              result_ch,
  output logic              eoc_n
);
  logic              srst_n;
  logic              wr_rise, cck_fall, start_ok, rd_hit, done;
  logic [CODE_W-1:0] fin_code;
  chan_e             ch_held, res_ch;

  sar_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_sync_n(srst_n));

  sar_edge_tap #(.RISE(1'b1), .IDLE_LV(1'b1)) u_wr_edge (
    .clk(clk), .rst_n(srst_n), .level(wr_n), .pulse(wr_rise));

  sar_edge_tap #(.RISE(1'b0), .IDLE_LV(1'b0)) u_cck_edge (
    .clk(clk), .rst_n(srst_n), .level(conv_clk), .pulse(cck_fall));

  assign start_ok = wr_rise & ~cs_n & ~busy;
  assign rd_hit   = ~cs_n & ~rd_n;

  sar_core #(.CODE_W(CODE_W)) u_core (
    .clk(clk), .rst_n(srst_n), .start(start_ok), .ch_in(chan_e'(ch_sel)),
    .step(cck_fall), .cmp_in(cmp_in), .busy(busy), .ch_held(ch_held),
    .trial(trial_code), .done(done), .fin_code(fin_code));

  sar_result_latch #(.CODE_W(CODE_W)) u_latch (
    .clk(clk), .rst_n(srst_n), .load(done), .code(fin_code), .ch(ch_held),
    .start(start_ok), .rd(rd_hit), .result(result), .result_ch(res_ch),
    .eoc_n(eoc_n));

  assign trial_ch  = ch_held;
  assign result_ch = res_ch;

  assert_flag_with_idle_R5: assert property (@(posedge clk) disable iff (!srst_n)
    $fell(eoc_n) |-> $fell(busy));
  assert_no_restart_R7: assert property (@(posedge clk) disable iff (!srst_n)
    (busy && wr_rise && !cs_n && !cck_fall) |=> busy);
  assert_desel_ignored_R9: assert property (@(posedge clk) disable iff (!srst_n)
    (!busy && cs_n) |=> !busy);
endmodule

// File: tb/sar_conv_seq_test.sv
module sar_conv_seq_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cs_n = 1'b1, wr_n = 1'b1, rd_n = 1'b1, ch_sel = 1'b0;
  logic       conv_clk = 1'b0;
  logic       cmp_in;
  logic [7:0] trial_code, result;
  logic       trial_ch, busy, result_ch, eoc_n;
  logic [7:0] va = 8'd0, vb = 8'd0;
  int         errs = 0, checks = 0, cyc = 0, falls = 0, fall_mark = 0;
  logic [1:0] div = 2'd0;
  logic       run_cck = 1'b0;

  always #4 clk = ~clk;

  sar_conv_seq uut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wr_n(wr_n), .rd_n(rd_n),
    .ch_sel(ch_sel), .conv_clk(conv_clk), .cmp_in(cmp_in),
    .trial_code(trial_code), .trial_ch(trial_ch), .busy(busy),
    .result(result), .result_ch(result_ch), .eoc_n(eoc_n));

  // ideal comparator on the held channel
  always_comb cmp_in = ((trial_ch ? vb : va) >= trial_code);

  // conversion clock: period of 4 system clocks
  always @(posedge clk) begin
    if (run_cck) begin
      div <= div + 2'd1;
      if (div[0]) begin
        conv_clk <= ~conv_clk;
        if (conv_clk) falls <= falls + 1;
      end
    end
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      errs = errs + 1;
      $display("FAIL watchdog: expired at cycle %0d (expected completion)", cyc);
      $display("Result: errors=%0d of %0d checks", errs, checks + 1);
      $finish;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic strobe_start(input logic ch);
    @(negedge clk);
    cs_n = 1'b0; ch_sel = ch; wr_n = 1'b0;
    @(negedge clk);
    wr_n = 1'b1; fall_mark = falls;
    @(negedge clk);
    cs_n = 1'b1;
  endtask

  task automatic wait_eoc(output bit seen);
    seen = 1'b0;
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      if (!eoc_n) begin seen = 1'b1; break; end
    end
  endtask

  // {channel, input A, input B}
  localparam logic [16:0] VEC [8] = '{
    {1'b0, 8'h00, 8'hFF}, {1'b1, 8'h00, 8'hFF}, {1'b0, 8'hFF, 8'h00},
    {1'b1, 8'h3C, 8'h80}, {1'b0, 8'h7F, 8'h11}, {1'b1, 8'h20, 8'h55},
    {1'b0, 8'hAA, 8'h01}, {1'b1, 8'hC3, 8'hFE}};

  initial begin
    bit seen;
    logic [7:0] keep;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk("R1 busy", busy, 0);
    chk("R1 eoc_n", eoc_n, 1);
    chk("R1 trial_code", trial_code, 0);
    chk("R1 result", result, 0);
    run_cck = 1'b1;
    repeat (4) @(negedge clk);

    for (int v = 0; v < 8; v++) begin
      logic ch;
      logic [7:0] exp;
      ch = VEC[v][16]; va = VEC[v][15:8]; vb = VEC[v][7:0];
      exp = ch ? vb : va;
      strobe_start(ch);
      chk("R2 busy after start", busy, 1);
      chk("R2 trial channel", trial_ch, ch);
      if (v > 0) chk("R8 flag cleared by start", eoc_n, 1);
      wait_eoc(seen);
      chk("R3 conversion completes", seen, 1);
      chk("R3 decision edges", falls - fall_mark, 8);
      chk("R4 result code", result, exp);
      chk("R5 result channel", result_ch, ch);
      chk("R5 busy cleared", busy, 0);
      chk("R6 register cleared", trial_code, 0);
    end

    // R2: first trial code is 0x80 before any decision
    va = 8'h42;
    @(negedge clk); cs_n = 1'b0; ch_sel = 1'b0; wr_n = 1'b0;
    @(negedge clk); wr_n = 1'b1; fall_mark = falls;
    @(negedge clk); cs_n = 1'b1;
    if (falls == fall_mark) chk("R2 initial trial", trial_code, 8'h80);
    // R7: strobe during conversion with other channel selected
    repeat (5) @(negedge clk);
    cs_n = 1'b0; ch_sel = 1'b1; wr_n = 1'b0; vb = 8'hEE;
    @(negedge clk); wr_n = 1'b1;
    @(negedge clk); cs_n = 1'b1;
    chk("R7 channel unchanged", trial_ch, 0);
    wait_eoc(seen);
    chk("R7 decision edges", falls - fall_mark, 8);
    chk("R7 result of first start", result, 8'h42);
    chk("R7 result channel", result_ch, 0);

    // R8: read releases the flag, result kept
    @(negedge clk); cs_n = 1'b0; rd_n = 1'b0;
    @(negedge clk); cs_n = 1'b1; rd_n = 1'b1;
    chk("R8 flag cleared by read", eoc_n, 1);
    chk("R8 result kept", result, 8'h42);

    // R9: strobe while deselected
    keep = result;
    @(negedge clk); cs_n = 1'b1; wr_n = 1'b0;
    @(negedge clk); wr_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R9 no start when deselected", busy, 0);
    chk("R9 flag unchanged", eoc_n, 1);
    chk("R9 result unchanged", result, keep);

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule